// File: doc/BRIEF.md
# Pin Interrupt Register Block

This block is the register and capture front end of a 32-input pin interrupt controller. Three control words select, bit by bit, which pins may interrupt (mask), whether a pin reacts to a rising edge or to a level (edge select), and whether a pin is taken as active-low (invert). None of these three words has an address of its own. Software changes each one only through a pair of alias registers: one sets bits and the other clears them. Either alias of a pair reads back the whole current word.

Each pin is XORed with its invert bit. The result is captured into a sticky latch word, either on a rising edge or while it is high. The request word is the latch ANDed with the mask, and a single registered interrupt line is the OR of all request bits. Software clears latched bits by writing ones to the latch register.

A simple synchronous register bus performs one access per strobe. Read data and a two-bit error code come back one cycle after the strobe. The reset value of the assign register is picked by an instance-number parameter, so several copies of the block can sit on one chip with different defaults.

Top module: `pin_irq_regs`

## Requirements
- R1: The word index is address bits [5:2] and fixes the register order. Index 0 is mask-set, 1 mask-clear, 2 request, 3 assign, 4 edge-set, 5 edge-clear, 6 invert-set, 7 invert-clear, 8 pin state and 9 latch. Byte offsets run from 0x00 to 0x24.
- R2: Mask, edge select and invert all reset to 0. A write to a set alias forces to 1 each bit of the underlying word written as 1, and leaves every bit written as 0 unchanged.
- R3: A write to a clear alias forces to 0 each bit of the underlying word written as 1, and leaves every other bit unchanged.
- R4: A read of either alias of a pair returns the full current value of the underlying word.
- R5: Assign is a plain read/write register. Its reset value comes from the INSTANCE parameter: 0 and 2 give 0x00000101, 1 gives 0x01010000, 3 gives 0x02020303. Any other value stops elaboration.
- R6: The access size is 2'b00 for a byte, 2'b01 for a half-word and 2'b10 for a word. Any size other than 2'b10 returns error code 1 and changes no state. This check wins over the offset check.
- R7: A word-size access to an offset that is not word-aligned, or whose word index is 10 or more, returns error code 2, read data 0, and changes no state.
- R8: When a pin's edge-select bit is 0, the latch bit is set in every cycle in which the pin XOR its invert bit is 1. The latch bit stays set after that input falls.
- R9: When a pin's edge-select bit is 1, the latch bit is set only on a 0-to-1 change of the pin XOR its invert bit. An input that stays high does not set it again after it has been cleared.
- R10: Writing 1 to a latch bit clears it. Request reads as latch AND mask. Writes to request and to pin state raise no error and have no effect.
- R11: irq_out is the OR of the request bits, delayed by one register: it changes one cycle after the request word does.
- R12: Read data and the error code appear in the cycle after the strobe and are 0 when there is no strobe. Pin state reads the pins XOR invert as registered one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Access size: 00 byte, 01 half-word, 10 word |
| bus_addr | input | ADDR_W | Byte offset inside the block |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, one cycle after the strobe |
| bus_err | output | 2 | 0 ok, 1 bad size, 2 bad offset, one cycle after the strobe |
| pins_in | input | DATA_W | Pin inputs, already synchronous to clk |
| irq_out | output | 1 | Registered interrupt request |

## Verification
A wrong alias update shows up on the next read of either alias of the pair, two cycles after the faulty write. It also shows up as an interrupt that fires or fails to fire once a pin is driven. A wrong latch or capture state reaches irq_out exactly one cycle after the latch changes, and it reaches the latch and pin-state reads two cycles after the pin changes, so the bench samples at those cycles. Decode faults show up as a wrong error code or as a changed register on the read that follows a rejected access. The bench therefore rereads the targeted word after every rejected write.

// File: rtl/pin_irq_pkg.sv
// Shared definitions for the pin interrupt register block.
// Assumes 32-bit words and a word index taken from address bits [5:2].
package pin_irq_pkg;
    localparam int NUM_WORDS = 10;
    localparam int NUM_ALIAS = 3;

    typedef enum logic [3:0] {
        W_MASK_SET = 4'd0,
        W_MASK_CLR = 4'd1,
        W_REQ      = 4'd2,
        W_ASSIGN   = 4'd3,
        W_EDGE_SET = 4'd4,
        W_EDGE_CLR = 4'd5,
        W_INV_SET  = 4'd6,
        W_INV_CLR  = 4'd7,
        W_PINS     = 4'd8,
        W_LATCH    = 4'd9
    } word_idx_e;

    typedef enum logic [1:0] {
        ERR_NONE   = 2'd0,
        ERR_WIDTH  = 2'd1,
        ERR_OFFSET = 2'd2
    } err_e;

    localparam logic [1:0] SIZE_WORD = 2'b10;

    // Word index of the set alias for hidden word g (0 mask, 1 edge, 2 invert).
    function automatic logic [3:0] alias_set_idx(int g);
        case (g)
            0:       return 4'(W_MASK_SET);
            1:       return 4'(W_EDGE_SET);
            default: return 4'(W_INV_SET);
        endcase
    endfunction

    // Reset value of the assign register for a given instance number.
    function automatic logic [31:0] assign_reset(int inst);
        case (inst)
            0, 2:    return 32'h0000_0101;
            1:       return 32'h0101_0000;
            3:       return 32'h0202_0303;
            default: return 32'h0000_0000;
        endcase
    endfunction

    function automatic bit instance_legal(int inst);
        return (inst >= 0) && (inst <= 3);
    endfunction
endpackage

// File: rtl/pin_irq_decode.sv
// Address and size decoder for the pin interrupt register block.
// Purely combinational. The size check takes priority over the offset check.
// Assumes ADDR_W >= 7 so that bits above the word index exist.
module pin_irq_decode #(
    parameter int ADDR_W = 8
) (
    input  logic                   sel,
    input  logic [1:0]             size,
    input  logic [ADDR_W-1:0]      addr,
    output pin_irq_pkg::word_idx_e idx,
    output pin_irq_pkg::err_e      err,
    output logic                   ok
);
    import pin_irq_pkg::*;

    logic [3:0] raw_idx;
    logic       hi_zero;

    assign raw_idx = addr[5:2];
    assign hi_zero = (addr[ADDR_W-1:6] == '0);
    assign idx     = word_idx_e'(raw_idx);

    // Classify the access: width first, then alignment and range.
    always_comb begin
        err = ERR_NONE;
        if (sel) begin
            if (size != SIZE_WORD)
                err = ERR_WIDTH;
            else if (addr[1:0] != 2'b00 || !hi_zero || raw_idx >= 4'(NUM_WORDS))
                err = ERR_OFFSET;
        end
    end

    assign ok = sel && (err == ERR_NONE);
endmodule

// File: rtl/pin_irq_alias.sv
// One hidden control word that is reached only through a set alias and a
// clear alias. Only bits written as 1 change. Set wins if both strobes are
// seen in the same cycle (the decoder never produces both).
module pin_irq_alias #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    // Bitwise set or clear of the hidden word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (set_we)
            q <= q | wdata;
        else if (clr_we)
            q <= q & ~wdata;
    end

    assert_set_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> ((q & $past(wdata)) == $past(wdata)));

    assert_clear_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && !set_we) |=> ((q & $past(wdata)) == '0));

    assert_hold_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_we || clr_we) |=> $stable(q));
endmodule

// File: rtl/pin_irq_capture.sv
// Pin capture: each pin is XORed with its invert bit, then latched either on
// a rising edge or on a high level, as the edge-select bit chooses. Latched bits
// are sticky until cleared by a write-one. A new hit wins over a clear in the
// same cycle. Pins are assumed already synchronous to clk.
module pin_irq_capture #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins,
    input  logic [W-1:0] invert,
    input  logic [W-1:0] edge_sel,
    input  logic         clr_we,
    input  logic [W-1:0] clr_data,
    output logic [W-1:0] latch_q,
    output logic [W-1:0] level_q
);
    logic [W-1:0] cond;
    logic [W-1:0] hit;
    logic [W-1:0] clr_mask;

    assign cond     = pins ^ invert;
    assign clr_mask = clr_we ? clr_data : '0;

    // Per-pin hit selection: rising edge or level.
    for (genvar i = 0; i < W; i++) begin : g_pin
        assign hit[i] = edge_sel[i] ? (cond[i] & ~level_q[i]) : cond[i];
    end

    // Previous-cycle conditioned pin state, used for edges and readback.
    always_ff @(posedge clk) begin
        if (!rst_n)
            level_q <= '0;
        else
            level_q <= cond;
    end

    // Sticky latch with write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            latch_q <= '0;
        else
            latch_q <= (latch_q & ~clr_mask) | hit;
    end

    assert_hit_latched_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit) |=> ((latch_q & $past(hit)) == $past(hit)));

    assert_no_spurious_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hit == '0) |=> ((latch_q & ~$past(latch_q)) == '0));
endmodule

// File: rtl/pin_irq_regs.sv
// Top of the pin interrupt register block: bus decode, three alias-reached
// control words, the assign register, the pin capture and the registered
// interrupt. Read data and the error code are registered, one cycle after the
// strobe. INSTANCE selects the assign reset value; only 0 to 3 are legal.
module pin_irq_regs #(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 8,
    parameter int INSTANCE = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [1:0]        bus_size,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [1:0]        bus_err,
    input  logic [DATA_W-1:0] pins_in,
    output logic              irq_out
);
    import pin_irq_pkg::*;

    localparam logic [DATA_W-1:0] ASSIGN_RST = DATA_W'(assign_reset(INSTANCE));

    if (!instance_legal(INSTANCE)) begin : g_bad_instance
        $error("pin_irq_regs: INSTANCE must be 0 to 3");
    end

    word_idx_e         idx;
    err_e              dec_err;
    logic              acc_ok;
    logic              wr_ok;
    logic [DATA_W-1:0] ctl_q [NUM_ALIAS];
    logic [DATA_W-1:0] mask_q, edge_q, inv_q;
    logic [DATA_W-1:0] assign_q;
    logic [DATA_W-1:0] latch_q, level_q;
    logic [DATA_W-1:0] request;
    logic [DATA_W-1:0] rd_val;

    pin_irq_decode #(.ADDR_W(ADDR_W)) u_decode (
        .sel  (bus_sel),
        .size (bus_size),
        .addr (bus_addr),
        .idx  (idx),
        .err  (dec_err),
        .ok   (acc_ok)
    );

    assign wr_ok = acc_ok && bus_we;

    // Hidden words 0 mask, 1 edge select, 2 invert; clear alias is set index + 1.
    for (genvar g = 0; g < NUM_ALIAS; g++) begin : g_alias
        localparam logic [3:0] SET_IDX = alias_set_idx(g);
        localparam logic [3:0] CLR_IDX = SET_IDX + 4'd1;
        pin_irq_alias #(.W(DATA_W)) u_word (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_we (wr_ok && (4'(idx) == SET_IDX)),
            .clr_we (wr_ok && (4'(idx) == CLR_IDX)),
            .wdata  (bus_wdata),
            .q      (ctl_q[g])
        );
    end

    assign mask_q = ctl_q[0];
    assign edge_q = ctl_q[1];
    assign inv_q  = ctl_q[2];

    // Plain assign register with per-instance reset value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            assign_q <= ASSIGN_RST;
        else if (wr_ok && idx == W_ASSIGN)
            assign_q <= bus_wdata;
    end

    pin_irq_capture #(.W(DATA_W)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .pins     (pins_in),
        .invert   (inv_q),
        .edge_sel (edge_q),
        .clr_we   (wr_ok && idx == W_LATCH),
        .clr_data (bus_wdata),
        .latch_q  (latch_q),
        .level_q  (level_q)
    );

    assign request = latch_q & mask_q;

    // Read multiplexer: both aliases of a pair return the hidden word.
    always_comb begin
        case (idx)
            W_MASK_SET, W_MASK_CLR: rd_val = mask_q;
            W_EDGE_SET, W_EDGE_CLR: rd_val = edge_q;
            W_INV_SET,  W_INV_CLR:  rd_val = inv_q;
            W_REQ:                  rd_val = request;
            W_ASSIGN:               rd_val = assign_q;
            W_PINS:                 rd_val = level_q;
            W_LATCH:                rd_val = latch_q;
            default:                rd_val = '0;
        endcase
    end

    // Registered read data and error code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
            bus_err   <= 2'(ERR_NONE);
        end else begin
            bus_rdata <= (acc_ok && !bus_we) ? rd_val : '0;
            bus_err   <= 2'(dec_err);
        end
    end

    // Registered interrupt output.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_out <= 1'b0;
        else
            irq_out <= |request;
    end

    assert_width_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_size != SIZE_WORD) |=> (bus_err == 2'(ERR_WIDTH)));

    assert_bad_access_keeps_assign_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && dec_err != ERR_NONE) |=> ($stable(assign_q) && bus_rdata == '0));

    assert_irq_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (|request) |=> irq_out);

    assert_irq_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(|request) |=> !irq_out);

    assert_idle_bus_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |=> (bus_err == 2'd0 && bus_rdata == '0));
endmodule

// File: tb/pin_irq_regs_tb.sv
// Self-checking bench for pin_irq_regs: a vector table walked by one loop,
// then directed tests for reset, errors, capture modes and the interrupt.
module pin_irq_regs_tb;
    localparam int DW = 32;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_we = 1'b0;
    logic [1:0]    bus_size = 2'b10;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic [1:0]    bus_err;
    logic [DW-1:0] pins_in = '0;
    logic          irq_out;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    pin_irq_regs #(.DATA_W(DW), .ADDR_W(AW), .INSTANCE(0)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_err(bus_err), .pins_in(pins_in),
        .irq_out(irq_out)
    );

    typedef struct packed {
        logic        we;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [1:0]  exp_err;
    } vec_t;

    localparam int NVEC = 21;
    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 8'h0C, 32'h0, 32'h0000_0101, 2'd0},         // R5 reset of assign, R1 index 3
        '{1'b0, 8'h00, 32'h0, 32'h0,         2'd0},         // R2 mask resets to 0
        '{1'b1, 8'h00, 32'hF0F0_0000, 32'h0, 2'd0},         // R2 set
        '{1'b0, 8'h04, 32'h0, 32'hF0F0_0000, 2'd0},         // R4 clear alias reads mask
        '{1'b1, 8'h00, 32'h0000_000F, 32'h0, 2'd0},         // R2 set more
        '{1'b0, 8'h00, 32'h0, 32'hF0F0_000F, 2'd0},         // R2 zeros left alone
        '{1'b1, 8'h04, 32'hF000_0001, 32'h0, 2'd0},         // R3 clear
        '{1'b0, 8'h04, 32'h0, 32'h00F0_000E, 2'd0},         // R3 result
        '{1'b1, 8'h10, 32'h0000_00FF, 32'h0, 2'd0},         // R1 edge set at index 4
        '{1'b1, 8'h14, 32'h0000_000F, 32'h0, 2'd0},         // R1 edge clear at index 5
        '{1'b0, 8'h14, 32'h0, 32'h0000_00F0, 2'd0},         // R4 edge pair
        '{1'b1, 8'h18, 32'hAAAA_0000, 32'h0, 2'd0},         // R1 invert set at index 6
        '{1'b0, 8'h1C, 32'h0, 32'hAAAA_0000, 2'd0},         // R4 invert pair
        '{1'b1, 8'h1C, 32'hAAAA_0000, 32'h0, 2'd0},         // R3 invert clear
        '{1'b0, 8'h18, 32'h0, 32'h0,         2'd0},         // R3 invert back to 0
        '{1'b1, 8'h0C, 32'h1234_5678, 32'h0, 2'd0},         // R5 assign write
        '{1'b0, 8'h0C, 32'h0, 32'h1234_5678, 2'd0},         // R5 assign readback
        '{1'b0, 8'h28, 32'h0, 32'h0,         2'd2},         // R7 index 10 read
        '{1'b1, 8'h28, 32'hFFFF_FFFF, 32'h0, 2'd2},         // R7 index 10 write
        '{1'b0, 8'h02, 32'h0, 32'h0,         2'd2},         // R7 misaligned
        '{1'b0, 8'h0C, 32'h0, 32'h1234_5678, 2'd0}          // R7 no state change
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic acc(input logic we, input logic [1:0] sz, input logic [7:0] a,
                       input logic [31:0] d, output logic [31:0] rd, output logic [1:0] er);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = we; bus_size = sz; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        rd = bus_rdata; er = bus_err;
        bus_sel = 1'b0; bus_we = 1'b0; bus_size = 2'b10; bus_addr = '0; bus_wdata = '0;
    endtask

    task automatic wr(input string req, input logic [7:0] a, input logic [31:0] d);
        logic [31:0] rd; logic [1:0] er;
        acc(1'b1, 2'b10, a, d, rd, er);
        check({req, " write err"}, 32'(er), 32'd0);
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] rd; logic [1:0] er;
        acc(1'b0, 2'b10, a, 32'h0, rd, er);
        check({req, " read data"}, rd, exp);
        check({req, " read err"}, 32'(er), 32'd0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        logic [31:0] rd;
        logic [1:0]  er;
        do_reset();
        // R12 reset and idle state
        check("R12 reset rdata", bus_rdata, 32'h0);
        check("R12 reset err", 32'(bus_err), 32'h0);
        check("R11 reset irq", 32'(irq_out), 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            acc(VEC[i].we, 2'b10, VEC[i].addr, VEC[i].data, rd, er);
            if (!VEC[i].we)
                check($sformatf("table row %0d data", i), rd, VEC[i].exp);
            check($sformatf("table row %0d err", i), 32'(er), 32'(VEC[i].exp_err));
        end

        do_reset();
        // R6 narrow write rejected, no state change
        acc(1'b1, 2'b01, 8'h00, 32'hFFFF_FFFF, rd, er);
        check("R6 half write err", 32'(er), 32'd1);
        rd_chk("R6 mask unchanged", 8'h00, 32'h0);
        // R6 priority over offset
        acc(1'b0, 2'b00, 8'h41, 32'h0, rd, er);
        check("R6 width before offset", 32'(er), 32'd1);
        check("R6 rejected read data", rd, 32'h0);

        // R8 level capture, R11 interrupt delay
        wr("R10 mask all", 8'h00, 32'hFFFF_FFFF);
        @(negedge clk); pins_in = 32'h1;
        @(posedge clk); #1;
        check("R11 irq lags latch", 32'(irq_out), 32'd0);
        @(posedge clk); #1;
        check("R11 irq after one cycle", 32'(irq_out), 32'd1);
        @(negedge clk); pins_in = 32'h0;
        rd_chk("R8 latch sticky", 8'h24, 32'h1);
        rd_chk("R12 pin state low", 8'h20, 32'h0);
        wr("R10 clear latch", 8'h24, 32'h1);
        rd_chk("R10 latch cleared", 8'h24, 32'h0);
        check("R11 irq dropped", 32'(irq_out), 32'd0);

        // R9 edge capture
        wr("R9 edge bit4", 8'h10, 32'h10);
        @(negedge clk); pins_in = 32'h10;
        rd_chk("R9 rising latched", 8'h24, 32'h10);
        wr("R9 clear while high", 8'h24, 32'h10);
        rd_chk("R9 no relatch while high", 8'h24, 32'h0);
        rd_chk("R12 pin state high", 8'h20, 32'h10);
        @(negedge clk); pins_in = 32'h0;
        @(negedge clk); pins_in = 32'h10;
        rd_chk("R9 second rise", 8'h24, 32'h10);

        // R10 request path and ignored writes
        wr("R10 mask clear bit4", 8'h04, 32'h10);
        rd_chk("R10 request masked", 8'h08, 32'h0);
        check("R11 irq masked", 32'(irq_out), 32'd0);
        wr("R10 request write", 8'h08, 32'hFFFF_FFFF);
        rd_chk("R10 request write ignored", 8'h08, 32'h0);
        wr("R10 pin state write", 8'h20, 32'hFFFF_FFFF);
        rd_chk("R10 pin state write ignored", 8'h20, 32'h10);
        wr("R10 mask set bit4", 8'h00, 32'h10);
        rd_chk("R10 request unmasked", 8'h08, 32'h10);

        // R8 with invert: low pin 8 becomes active
        wr("R8 invert bit8", 8'h18, 32'h100);
        rd_chk("R12 pin state inverted", 8'h20, 32'h110);
        rd_chk("R8 inverted level latched", 8'h24, 32'h110);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        finished = 1'b1;
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule